// File: doc/BRIEF.md
# Interrupt Master-Enable Dispatch Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It keeps one pending flag and one enable flag per source, and the core reads and writes both through a narrow register port. A master-enable bit decides whether an enabled, pending request may be taken. The core sets this bit with an enable strobe or a return-with-enable strobe. A disable strobe clears it, and taking an interrupt also clears it. A plain return strobe leaves it unchanged. Pending flags latch hardware requests whatever the master-enable state is, so software can poll for them. A software write can also raise a pending flag, and such a flag is dispatched exactly like a hardware request.

When a request may be taken, the block offers a dispatch on a valid/ready pair. When the core accepts it, the block clears the master-enable bit and the pending bit of the winning source. It then streams the two bytes of the interrupted return address to the core's stack writer on a second valid/ready pair: the high byte first, to the higher address, and the low byte second, to the lower address. Last, it presents the vector address on a third valid/ready pair. A halt-wake output tells a halted core that an enabled request is pending, even while the master enable is off.

Back-pressure rules: `push_valid` and `jump_valid` stay high, with their data held stable, until the matching ready is seen high at a clock edge. `disp_valid` is an offer, and it is withdrawn if the master enable is cleared before the core accepts. The winning source and the return address are captured in the accept cycle.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset, both flag registers read 0, the master enable is 0, and all valid outputs are 0.
- R2: A pulse on `hw_req[i]` sets pending bit i whether or not the master enable is set. The timer source is bit 2, and reads back as 0x04 on the pending register (`reg_sel`=0).
- R3: A write to the pending register (`reg_sel`=0) loads bits [4:0] from `reg_wdata`. A bit set this way dispatches exactly as a hardware request would. A write to the enable register (`reg_sel`=1) loads the enable flags.
- R4: `disp_valid` is high only when the master enable is 1, the sequencer is idle and (pending AND enable) is non-zero. A request whose enable bit is 0, or one raised while the master enable is 0, stays pending and is not dispatched.
- R5: The cycle after `disp_valid && disp_ready`, the master enable is 0 and the winning source's pending bit is 0. The other pending bits are unchanged.
- R6: Among the enabled pending requests, the lowest-numbered bit wins. Its vector is 0x0040 + 8 × bit index, so the timer (bit 2) vectors to 0x0050.
- R7: After acceptance, two pushes follow. The first has `push_hi`=1 and carries `ret_addr[15:8]`. The second has `push_hi`=0 and carries `ret_addr[7:0]`, captured at accept. Then `jump_valid` presents the vector.
- R8: `ime_set` or `ret_en` sets the master enable. `ime_clr` clears it. `ret_plain` leaves it as it is. A dispatch accept clears it, overriding every strobe in the same cycle.
- R9: `halt_wake` is 1 exactly when (pending AND enable) is non-zero, regardless of the master enable.
- R10: When a hardware request and a pending-register write hit the same bit in one cycle, the bit ends up set.
- R11: While `push_valid` or `jump_valid` is high and its ready is low, the valid and its payload hold unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = pending register, 1 = enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, unused bits 0 |
| hw_req | input | 5 | Hardware request pulses, one per source |
| ime_set | input | 1 | Enable-interrupts strobe |
| ime_clr | input | 1 | Disable-interrupts strobe |
| ret_plain | input | 1 | Plain return strobe |
| ret_en | input | 1 | Return-with-enable strobe |
| ret_addr | input | 16 | Address of the interrupted instruction |
| disp_valid | output | 1 | Dispatch offered |
| disp_ready | input | 1 | Core accepts dispatch |
| push_valid | output | 1 | Stack byte valid |
| push_ready | input | 1 | Stack writer accepts byte |
| push_hi | output | 1 | 1 = high byte (first push), 0 = low byte |
| push_data | output | 8 | Stack byte |
| jump_valid | output | 1 | Vector valid |
| jump_ready | input | 1 | Core takes vector |
| jump_addr | output | 16 | Vector address |
| ime | output | 1 | Master-enable state |
| halt_wake | output | 1 | Enabled request pending |

## Verification
The hardest case to reach from the ports is the full cross of pending patterns with enable patterns. Each pair must be seen both with the master enable off, where nothing may dispatch, and with it on, where the lowest enabled bit must win. To get there, the bench walks all 31 × 31 non-zero pairs. It loads each pair by register writes with the master enable cleared, then raises the enable. It runs the complete accept, push and jump sequence, with one cycle of push back-pressure, and reads the pending register back afterwards. A collision of a hardware request with a pending-register write is then driven in a single cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_PUSH_HI = 2'd1,
    SQ_PUSH_LO = 2'd2,
    SQ_JUMP    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [NSRC-1:0] hw_req,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] en,
  output logic [DW-1:0]   reg_rdata
);
  logic [NSRC-1:0] pend_nx;

  // software write, then service clear, then hardware set (hardware wins)
  always_comb begin
    pend_nx = pend;
    if (reg_we && !reg_sel) pend_nx = reg_wdata[NSRC-1:0];
    pend_nx = pend_nx & ~clr_mask;
    pend_nx = pend_nx | hw_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= pend_nx;
      if (reg_we && reg_sel) en <= reg_wdata[NSRC-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[NSRC-1:0] = reg_sel ? en : pend;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC       = 5,
  parameter int AW         = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8
) (
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [NSRC-1:0] grant,
  output logic [AW-1:0]   vec
);
  always_comb begin
    grant = '0;
    vec   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        vec = AW'(VEC_BASE + i * VEC_STRIDE);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_pkg::*;
#(
  parameter int NSRC = 5,
  parameter int DW   = 8,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ime_set,
  input  logic            ime_clr,
  input  logic            ret_plain,
  input  logic            ret_en,
  input  logic            want,
  input  logic [NSRC-1:0] grant,
  input  logic [AW-1:0]   vec,
  input  logic [AW-1:0]   ret_addr,
  output logic            disp_valid,
  input  logic            disp_ready,
  output logic [NSRC-1:0] clr_mask,
  output logic            push_valid,
  input  logic            push_ready,
  output logic            push_hi,
  output logic [DW-1:0]   push_data,
  output logic            jump_valid,
  input  logic            jump_ready,
  output logic [AW-1:0]   jump_addr,
  output logic            ime
);
  seq_state_t st;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] vec_q;
  logic accept;

  assign disp_valid = (st == SQ_IDLE) && ime && want;
  assign accept     = disp_valid && disp_ready;
  assign clr_mask   = accept ? grant : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ime <= 1'b0;
    end else if (accept) begin
      ime <= 1'b0;
    end else if (ime_clr) begin
      ime <= 1'b0;
    end else if (ime_set || ret_en) begin
      ime <= 1'b1;
    end else if (ret_plain) begin
      ime <= ime;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      ret_q <= '0;
      vec_q <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (accept) begin
          st    <= SQ_PUSH_HI;
          ret_q <= ret_addr;
          vec_q <= vec;
        end
        SQ_PUSH_HI: if (push_ready) st <= SQ_PUSH_LO;
        SQ_PUSH_LO: if (push_ready) st <= SQ_JUMP;
        SQ_JUMP:    if (jump_ready) st <= SQ_IDLE;
        default:    st <= SQ_IDLE;
      endcase
    end
  end

  assign push_valid = (st == SQ_PUSH_HI) || (st == SQ_PUSH_LO);
  assign push_hi    = (st == SQ_PUSH_HI);
  assign push_data  = push_hi ? ret_q[AW-1:AW-DW] : ret_q[DW-1:0];
  assign jump_valid = (st == SQ_JUMP);
  assign jump_addr  = vec_q;
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl #(
  parameter int NSRC       = 5,
  parameter int DW         = 8,
  parameter int AW         = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] hw_req,
  input  logic            ime_set,
  input  logic            ime_clr,
  input  logic            ret_plain,
  input  logic            ret_en,
  input  logic [AW-1:0]   ret_addr,
  output logic            disp_valid,
  input  logic            disp_ready,
  output logic            push_valid,
  input  logic            push_ready,
  output logic            push_hi,
  output logic [DW-1:0]   push_data,
  output logic            jump_valid,
  input  logic            jump_ready,
  output logic [AW-1:0]   jump_addr,
  output logic            ime,
  output logic            halt_wake
);
  logic [NSRC-1:0] pend, en, clr_mask, grant;
  logic            want;
  logic [AW-1:0]   vec;

  irq_flag_bank #(.NSRC(NSRC), .DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .hw_req(hw_req), .clr_mask(clr_mask),
    .pend(pend), .en(en), .reg_rdata(reg_rdata)
  );

  irq_arbiter #(.NSRC(NSRC), .AW(AW), .VEC_BASE(VEC_BASE),
                .VEC_STRIDE(VEC_STRIDE)) u_arb (
    .req(pend & en), .any(want), .grant(grant), .vec(vec)
  );

  irq_sequencer #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ime_set(ime_set), .ime_clr(ime_clr),
    .ret_plain(ret_plain), .ret_en(ret_en), .want(want), .grant(grant),
    .vec(vec), .ret_addr(ret_addr), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .clr_mask(clr_mask), .push_valid(push_valid),
    .push_ready(push_ready), .push_hi(push_hi), .push_data(push_data),
    .jump_valid(jump_valid), .jump_ready(jump_ready), .jump_addr(jump_addr),
    .ime(ime)
  );

  assign halt_wake = want;
endmodule

// File: rtl/irq_dispatch_sva.sv
module irq_dispatch_sva #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ime_set,
  input logic          ime_clr,
  input logic          ret_plain,
  input logic          ret_en,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic          push_valid,
  input logic          push_ready,
  input logic          push_hi,
  input logic [DW-1:0] push_data,
  input logic          jump_valid,
  input logic          jump_ready,
  input logic [AW-1:0] jump_addr,
  input logic          ime,
  input logic          halt_wake
);
  a_r4_offer_needs_ime: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ime && halt_wake);

  a_r5_accept_drops_ime: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> !ime && push_valid && push_hi);

  a_r7_low_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_ready && push_hi |=> push_valid && !push_hi);

  a_r7_jump_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_ready && !push_hi |=> jump_valid && !push_valid);

  a_r8_plain_ret_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ret_plain && !ret_en && !ime_set && !ime_clr && !(disp_valid && disp_ready)
    |=> ime == $past(ime));

  a_r9_wake_covers_offer: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_wake |-> !disp_valid);

  a_r11_push_held: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_hi) && $stable(push_data));

  a_r11_jump_held: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid && !jump_ready |=> jump_valid && $stable(jump_addr));
endmodule

bind irq_dispatch_ctrl irq_dispatch_sva #(.DW(DW), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .ime_set(ime_set), .ime_clr(ime_clr),
  .ret_plain(ret_plain), .ret_en(ret_en), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .push_valid(push_valid), .push_ready(push_ready),
  .push_hi(push_hi), .push_data(push_data), .jump_valid(jump_valid),
  .jump_ready(jump_ready), .jump_addr(jump_addr), .ime(ime),
  .halt_wake(halt_wake)
);

// File: tb/irq_dispatch_ctrl_bench.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [4:0] hw_req = 0;
  logic ime_set = 0, ime_clr = 0, ret_plain = 0, ret_en = 0;
  logic [15:0] ret_addr = 0;
  logic disp_valid, disp_ready = 0;
  logic push_valid, push_ready = 0, push_hi;
  logic [7:0] push_data;
  logic jump_valid, jump_ready = 0;
  logic [15:0] jump_addr;
  logic ime, halt_wake;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_dispatch_ctrl u_irq_dispatch_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .ime_set(ime_set), .ime_clr(ime_clr), .ret_plain(ret_plain),
    .ret_en(ret_en), .ret_addr(ret_addr), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .push_valid(push_valid), .push_ready(push_ready),
    .push_hi(push_hi), .push_data(push_data), .jump_valid(jump_valid),
    .jump_ready(jump_ready), .jump_addr(jump_addr), .ime(ime),
    .halt_wake(halt_wake)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    step();
    reg_we = 0; reg_sel = 0;
  endtask

  task automatic rd_pend(output logic [7:0] v);
    reg_sel = 0; #0.1; v = reg_rdata;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    rd_pend(v);
    check("R1 pending", v, 0);
    reg_sel = 1; #0.1;
    check("R1 enable", reg_rdata, 0);
    reg_sel = 0;
    check("R1 ime", ime, 0);
    check("R1 valids", {disp_valid, push_valid, jump_valid}, 0);

    // R2 hardware timer request latches with master enable off
    hw_req = 5'b00100; step(); hw_req = 0;
    rd_pend(v);
    check("R2 timer pending", v, 8'h04);
    check("R9 no wake when disabled", halt_wake, 0);
    wr(1, 8'h04);
    check("R9 wake with ime off", halt_wake, 1);
    check("R4 no offer with ime off", disp_valid, 0);

    // R10 collision: write 0 while hardware sets bit 0
    hw_req = 5'b00001; reg_we = 1; reg_sel = 0; reg_wdata = 8'h00;
    step();
    hw_req = 0; reg_we = 0;
    rd_pend(v);
    check("R10 hw wins", v, 8'h01);

    // R8 strobes
    ime_set = 1; step(); ime_set = 0;
    check("R8 ei sets", ime, 1);
    ime_clr = 1; step(); ime_clr = 0;
    check("R8 di clears", ime, 0);
    ret_en = 1; step(); ret_en = 0;
    check("R8 reti sets", ime, 1);
    ret_plain = 1; step(); ret_plain = 0;
    check("R8 plain ret keeps 1", ime, 1);
    ime_clr = 1; step(); ime_clr = 0;

    // sweep all pending x enable patterns
    for (int p = 1; p < 32; p++) begin
      for (int e = 1; e < 32; e++) begin
        int m;
        int idx;
        m = p & e;
        idx = -1;
        for (int b = 4; b >= 0; b--) if (m[b]) idx = b;
        wr(1, 8'(e));
        wr(0, 8'(p));
        rd_pend(v);
        check("R3 sw write pending", v, 32'(p));
        check("R9 wake", halt_wake, 32'(m != 0));
        check("R4 no offer ime off", disp_valid, 0);
        ime_set = 1; step(); ime_set = 0;
        if (m == 0) begin
          check("R4 disabled source not offered", disp_valid, 0);
          ime_clr = 1; step(); ime_clr = 0;
        end else begin
          ret_addr = 16'(16'hA500 + p * 37 + e);
          check("R4 offer", disp_valid, 1);
          disp_ready = 1; step(); disp_ready = 0;
          ret_addr = 16'h0;
          check("R5 ime cleared", ime, 0);
          rd_pend(v);
          check("R5 serviced bit cleared", v, 32'(p & ~(1 << idx)));
          check("R7 first push high", {push_valid, push_hi}, 2'b11);
          check("R7 high byte", push_data, 32'((16'hA500 + p * 37 + e) >> 8) & 32'hFF);
          step();
          check("R11 push held", {push_valid, push_hi}, 2'b11);
          push_ready = 1; step();
          check("R7 second push low", {push_valid, push_hi}, 2'b10);
          check("R7 low byte", push_data, 32'(16'hA500 + p * 37 + e) & 32'hFF);
          step(); push_ready = 0;
          check("R7 jump valid", jump_valid, 1);
          check("R6 vector", jump_addr, 32'(16'h0040 + 8 * idx));
          jump_ready = 1; step(); jump_ready = 0;
          check("R5 no re-offer", disp_valid, 0);
          ret_plain = 1; step(); ret_plain = 0;
          check("R8 plain ret leaves 0", ime, 0);
        end
        wr(0, 8'h00);
      end
    end

    // R2/R3 timer dispatch via hardware, vector 0x0050
    wr(1, 8'h04);
    hw_req = 5'b00100; step(); hw_req = 0;
    ret_en = 1; step(); ret_en = 0;
    check("R2 timer offered", disp_valid, 1);
    disp_ready = 1; step(); disp_ready = 0;
    push_ready = 1; step(); step(); push_ready = 0;
    check("R6 timer vector", jump_addr, 32'h0050);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule